// File: doc/BRIEF.md
# Cross-Lane Vector Permute Unit

This block rearranges the elements of a 256-bit vector. A selection may cross the 128-bit lane boundary, so any output element can take its data from anywhere in the full source. It performs one of three permutations per accepted request. The first is a word permute, where a second vector supplies one index for each 32-bit result word. The second is a doubleword permute steered by an 8-bit immediate. The third is a 128-bit half permute, also steered by the immediate, which can take each half from either the source vector or the previous destination value.

The caller presents the operation code, the source vector, the control vector, the old destination value and the immediate, all with a valid strobe. The permuted result is computed from these input values alone and appears in an output register one clock later, together with a registered valid flag. Instruction decode and register-file access are handled outside the block.

Top module: `xlane_permute`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears `result` to zero and `out_valid` to 0.
- R2: With `op` = 2'b00 (word permute), result word i (bits 32i+31..32i, i = 0..7) equals source word m, where m is the low byte of control word i taken modulo 8, which is bits 2..0 of that control word. The upper control bits have no effect.
- R3: With `op` = 2'b01 (doubleword permute), result doubleword n (bits 64n+63..64n, n = 0..3) equals source doubleword `imm[2n+1:2n]`. Immediate 0xE4 returns the source unchanged and 0x1B reverses it.
- R4: With `op` = 2'b10 (half permute), result half h (h = 0 low, 1 high) uses nibble `imm[4h+3:4h]`. Nibble bit 1 set selects the old destination and clear selects the source. Nibble bit 0 selects the high 128-bit half of that operand when set and the low half when clear.
- R5: In the half permute, bits 3..2 of each nibble do not change the result.
- R6: `op` = 2'b11 loads an all-zero result.
- R7: `out_valid` at a rising edge takes the value `in_valid` had at the previous rising edge, so a result accepted at one edge is valid after that edge.
- R8: When `in_valid` is low, `result` holds its previous value whatever the other inputs do.
- R9: All selections read the input values presented with the request, including when one output half comes from the old destination and the other from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; loads the result register |
| op | input | 2 | 00 word, 01 doubleword, 10 half, 11 zero |
| src_j | input | 256 | Source vector |
| ctl_k | input | 256 | Per-word index vector for the word permute |
| dst_old | input | 256 | Previous destination value |
| imm | input | 8 | Immediate selector |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 256 | Registered permuted vector |

## Verification
A wrong element index shows up as a misplaced word, doubleword or half in `result` one clock after the request. Every source element is tagged with its own position, so the bench can tell which index was used. A wrong operand choice in the half permute makes one half carry the destination tag instead of the source tag, or the reverse, and this is also visible after one clock. A bad load-enable or reset path shows up as `result` changing on an idle cycle, or as a stale value left after reset, at the next edge.

// File: rtl/xlane_permute_pkg.sv
package xlane_permute_pkg;

  typedef enum logic [1:0] {
    OP_WORD  = 2'b00,
    OP_DWORD = 2'b01,
    OP_HALF  = 2'b10,
    OP_ZERO  = 2'b11
  } perm_op_e;

  // bit offset of element number idx for elements of width elem_w
  function automatic int unsigned elem_base(input int unsigned idx, input int unsigned elem_w);
    return idx * elem_w;
  endfunction

endpackage

// File: rtl/word_perm_unit.sv
module word_perm_unit #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned NUM   = VEC_W / ELEM_W,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic [VEC_W-1:0]     src,
  input  logic [NUM*IDX_W-1:0] idx_flat,
  output logic [VEC_W-1:0]     dout
);
  import xlane_permute_pkg::*;

  for (genvar gi = 0; gi < NUM; gi++) begin : g_word
    logic [IDX_W-1:0] pick;
    assign pick = idx_flat[gi*IDX_W +: IDX_W];
    assign dout[gi*ELEM_W +: ELEM_W] = src[elem_base(pick, ELEM_W) +: ELEM_W];
  end
endmodule

// File: rtl/dword_perm_unit.sv
module dword_perm_unit #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned ELEM_W = 64,
  localparam int unsigned NUM   = VEC_W / ELEM_W,
  localparam int unsigned SEL_W = $clog2(NUM)
) (
  input  logic [VEC_W-1:0]     src,
  input  logic [NUM*SEL_W-1:0] sel_flat,
  output logic [VEC_W-1:0]     dout
);
  import xlane_permute_pkg::*;

  for (genvar gn = 0; gn < NUM; gn++) begin : g_dword
    logic [SEL_W-1:0] pick;
    assign pick = sel_flat[gn*SEL_W +: SEL_W];
    assign dout[gn*ELEM_W +: ELEM_W] = src[elem_base(pick, ELEM_W) +: ELEM_W];
  end
endmodule

// File: rtl/half_perm_unit.sv
module half_perm_unit #(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned HALF_W = VEC_W / 2
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [1:0]       take_old,   // per half: 1 = old destination
  input  logic [1:0]       take_high,  // per half: 1 = upper half of operand
  output logic [VEC_W-1:0] dout
);
  import xlane_permute_pkg::*;

  for (genvar gh = 0; gh < 2; gh++) begin : g_half
    logic [VEC_W-1:0] operand;
    assign operand = take_old[gh] ? old_dst : src;
    assign dout[gh*HALF_W +: HALF_W] = operand[elem_base(take_high[gh], HALF_W) +: HALF_W];
  end
endmodule

// File: rtl/xlane_permute.sv
module xlane_permute #(
  parameter int unsigned VEC_W   = 256,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DWORD_W = 64,
  parameter int unsigned IMM_W   = 8,
  localparam int unsigned NWORD  = VEC_W / WORD_W,
  localparam int unsigned WIDX_W = $clog2(NWORD),
  localparam int unsigned HALF_W = VEC_W / 2,
  localparam int unsigned NIB_W  = IMM_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [VEC_W-1:0] src_j,
  input  logic [VEC_W-1:0] ctl_k,
  input  logic [VEC_W-1:0] dst_old,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  import xlane_permute_pkg::*;

  // low index bits of each control word: low byte modulo word count
  logic [NWORD*WIDX_W-1:0] word_idx;
  for (genvar gw = 0; gw < NWORD; gw++) begin : g_idx
    assign word_idx[gw*WIDX_W +: WIDX_W] = ctl_k[gw*WORD_W +: WIDX_W];
  end
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^ctl_k;

  // half-permute selectors: nibble bit 1 picks operand, bit 0 picks half
  logic [1:0] half_take_old;
  logic [1:0] half_take_high;
  assign half_take_old  = {imm[NIB_W+1], imm[1]};
  assign half_take_high = {imm[NIB_W],   imm[0]};

  logic [VEC_W-1:0] word_res;
  logic [VEC_W-1:0] dword_res;
  logic [VEC_W-1:0] half_res;
  logic [VEC_W-1:0] perm_next;

  word_perm_unit #(.VEC_W(VEC_W), .ELEM_W(WORD_W)) u_word (
    .src(src_j), .idx_flat(word_idx), .dout(word_res)
  );

  dword_perm_unit #(.VEC_W(VEC_W), .ELEM_W(DWORD_W)) u_dword (
    .src(src_j), .sel_flat(imm), .dout(dword_res)
  );

  half_perm_unit #(.VEC_W(VEC_W)) u_half (
    .src(src_j), .old_dst(dst_old), .take_old(half_take_old),
    .take_high(half_take_high), .dout(half_res)
  );

  always_comb begin
    case (perm_op_e'(op))
      OP_WORD:  perm_next = word_res;
      OP_DWORD: perm_next = dword_res;
      OP_HALF:  perm_next = half_res;
      default:  perm_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= perm_next;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R6
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> result == '0);
  // R3
  dword_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && imm == 8'hE4) |=> result == $past(src_j));
  // R4
  half_old_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && imm[1:0] == 2'b10) |=>
      result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]));
  // R2
  word0_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=>
      result[WORD_W-1:0] == $past(src_j[ctl_k[WIDX_W-1:0]*WORD_W +: WORD_W]));
endmodule

// File: tb/tb_xlane_permute.sv
module tb_xlane_permute;
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  imm;
    logic [23:0] kidx;  // eight 3-bit word indices, word 0 in bits 2..0
    logic [7:0]  seed;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TABLE [NVEC] = '{
    '{2'b00, 8'h00, 24'hFAC688, 8'h11},  // R2 identity 0..7
    '{2'b00, 8'h00, 24'h053977, 8'h12},  // R2 reversal 7..0
    '{2'b00, 8'h00, 24'hB6DB6D, 8'h13},  // R2 all index 5
    '{2'b01, 8'hE4, 24'h000000, 8'h21},  // R3 identity
    '{2'b01, 8'h1B, 24'h000000, 8'h22},  // R3 reversal
    '{2'b01, 8'h72, 24'h000000, 8'h23},  // R3 mixed
    '{2'b10, 8'h10, 24'h000000, 8'h31},  // R4 source identity
    '{2'b10, 8'h01, 24'h000000, 8'h32},  // R4 source halves swapped
    '{2'b10, 8'h32, 24'h000000, 8'h33},  // R4 old destination identity
    '{2'b10, 8'hFE, 24'h000000, 8'h33},  // R5 same as 0x32 with high nibble bits set
    '{2'b10, 8'hC9, 24'h000000, 8'h34},  // R5 swap via ignored bits
    '{2'b10, 8'h12, 24'h000000, 8'h35},  // R9 low from old dest, high from source
    '{2'b11, 8'hE4, 24'hFAC688, 8'h41}   // R6 zero op
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   op = '0;
  logic [255:0] src_j = '0, ctl_k = '0, dst_old = '0;
  logic [7:0]   imm = '0;
  logic         out_valid;
  logic [255:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xlane_permute dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_j(src_j),
    .ctl_k(ctl_k), .dst_old(dst_old), .imm(imm), .out_valid(out_valid),
    .result(result)
  );

  function automatic logic [255:0] mk_j(input logic [7:0] s);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = {8'hA5, s, 8'h3C, 8'(w)};
    return v;
  endfunction

  function automatic logic [255:0] mk_d(input logic [7:0] s);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = {8'hD7, s, 8'hC3, 8'(w)};
    return v;
  endfunction

  function automatic logic [255:0] mk_k(input logic [23:0] kidx, input logic [7:0] s);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = {s, 16'hC3A5, 5'b10110, kidx[w*3 +: 3]};
    return v;
  endfunction

  function automatic logic [255:0] model(input logic [1:0] o, input logic [7:0] im,
      input logic [255:0] j, input logic [255:0] k, input logic [255:0] d);
    logic [255:0] r;
    r = '0;
    case (o)
      2'b00: for (int i = 0; i < 8; i++) begin
        int m;
        m = int'(k[i*32 +: 8]) % 8;
        r[i*32 +: 32] = j[m*32 +: 32];
      end
      2'b01: for (int n = 0; n < 4; n++) r[n*64 +: 64] = j[int'(im[2*n +: 2])*64 +: 64];
      2'b10: for (int h = 0; h < 2; h++) begin
        logic [3:0] nib;
        logic [255:0] opnd;
        nib = im[4*h +: 4];
        opnd = nib[1] ? d : j;
        r[h*128 +: 128] = nib[0] ? opnd[255:128] : opnd[127:0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] o, input logic [7:0] im);
    case (o)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return (im == 8'hFE || im == 8'hC9) ? "R5" : ((im == 8'h12) ? "R9" : "R4");
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [7:0] im, input logic [255:0] j,
      input logic [255:0] k, input logic [255:0] d);
    @(negedge clk);
    op = o; imm = im; src_j = j; ctl_k = k; dst_old = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", result, '0);
    check("R1", {255'd0, out_valid}, '0);
    rst = 1'b0;

    for (int t = 0; t < NVEC; t++) begin
      logic [255:0] j, k, d;
      j = mk_j(TABLE[t].seed);
      k = mk_k(TABLE[t].kidx, TABLE[t].seed);
      d = mk_d(TABLE[t].seed);
      issue(TABLE[t].op, TABLE[t].imm, j, k, d);
      check(req_of(TABLE[t].op, TABLE[t].imm), result, model(TABLE[t].op, TABLE[t].imm, j, k, d));
      // R7 valid one cycle after request
      check("R7", {255'd0, out_valid}, 256'd1);
    end

    // R3 identity gives the source back unchanged
    issue(2'b01, 8'hE4, mk_j(8'h55), '0, mk_d(8'h55));
    check("R3", result, mk_j(8'h55));
    held = result;

    // R8 idle cycles with changing inputs leave result alone
    @(negedge clk);
    op = 2'b11; imm = 8'h00; src_j = mk_j(8'h99); dst_old = mk_d(8'h99);
    @(negedge clk);
    check("R8", result, held);
    // R7 valid drops when no request
    check("R7", {255'd0, out_valid}, '0);

    // R5 ignored nibble bits: 0x01 vs 0xCD equal
    issue(2'b10, 8'hCD, mk_j(8'h66), '0, mk_d(8'h66));
    check("R5", result, {mk_j(8'h66)[127:0], mk_j(8'h66)[255:128]});

    // R1 reset after a load clears the register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, '0);
    check("R1", {255'd0, out_valid}, '0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule